// File: doc/BRIEF.md
# PHY Management Bus Master

This block drives the two-wire PHY management interface from a small set of registers. Software picks a clock divider and an optional preamble skip in a mode register. It loads the target PHY address, the target register address and, for writes, a data word. It then starts a transfer with a command write. The block produces the management clock from the system clock and shifts out the serial frame. On a read it releases the data line at the turnaround and captures the sixteen data bits the PHY returns.

A scan command makes the block read the selected register over and over, with no gap between frames. Each completed scan frame refreshes the read-data register and a link-fail flag. A data-invalid flag stays set from the scan command until the first scan frame has finished. A status register shows busy, link-fail and data-invalid at all times. After each transfer, software writes zero to the command register before it issues the next command.

Top module: `mdio_master`

## Requirements
- R1: The management clock period equals the mode divider field (mode bits 7:0) in system clocks. Bit 0 of that field is ignored, and any value below 2 acts as 2. The clock runs continuously after reset.
- R2: Each frame begins with 32 one bits of preamble. When mode bit 8 is set, no preamble is sent and the frame opens directly with its start bits.
- R3: Command value 4 (bit 2) sends a write frame. The frame carries start 01, opcode 01, the PHY address (address register bits 4:0), the register address (address register bits 12:8), turnaround 10 and the 16 transmit-data bits, MSB first. A write to a PHY address nobody answers changes no PHY register.
- R4: Command value 2 (bit 1) sends a read frame with opcode 10. The master stops driving the line from the first turnaround bit and samples on rising clock edges. The 16 data bits land in the read-data register (register 4). An unanswered read returns all ones from the pulled-up line.
- R5: Status bit 1 (busy) is set from the accepted command write until the frame ends. The data line is driven only while busy is set.
- R6: The data line value and its output enable change only at the edge where the management clock falls.
- R7: Command value 1 (bit 0) starts a scan: read frames follow each other with no gap. Each finished frame updates read data, and sets status bit 0 (link fail) to the inverse of bit 2 of the word read. Status bit 2 (invalid) is set by the scan command and clears when the first scan frame completes.
- R8: Writing 0 to the command register during a scan lets the current frame finish. No further frame starts, and busy drops.
- R9: A nonzero command written while busy is ignored. No extra frame is sent.
- R10: After reset, status, read data and the management clock are 0, and the data line is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 mode, 1 command, 2 address, 3 tx data, 4 rx data, 5 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input (pulled up when undriven) |

## Verification
Single transfers mix writes, reads and reads to an absent PHY. They run with and without preamble. Their divider values are even, odd, zero, one and the largest. The measured clock period separates the forced-even rule from a divider that passes bit 0 through. Data words of all ones, all zeros and mixed bits at the top and bottom catch a shift that is reversed or off by one. A read of an address that was written to an absent PHY shows that the write reached nobody. Directed runs cover a command written while busy, a scan whose status word changes between frames, and a scan that is stopped.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  typedef enum logic [2:0] {
    SEL_MODE   = 3'd0,
    SEL_CMD    = 3'd1,
    SEL_ADDR   = 3'd2,
    SEL_TXD    = 3'd3,
    SEL_RXD    = 3'd4,
    SEL_STATUS = 3'd5
  } reg_sel_e;

  localparam int CMD_SCAN  = 0;
  localparam int CMD_READ  = 1;
  localparam int CMD_WRITE = 2;

  localparam int ST_LINKFAIL = 0;
  localparam int ST_BUSY     = 1;
  localparam int ST_INVALID  = 2;

  localparam int REGAD_LSB   = 8;
  localparam int LINK_BIT    = 2;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_field,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  localparam int HW = DIV_W - 1;

  logic [HW-1:0] half, cnt;
  logic          hit;

  // bit 0 dropped; half period of zero is raised to one
  assign half = (div_field[DIV_W-1:1] == '0) ? HW'(1) : div_field[DIV_W-1:1];
  assign hit  = (cnt >= half - HW'(1));
  assign rise_stb = hit & ~mdc;
  assign fall_stb = hit & mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (hit) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + HW'(1);
    end
  end
endmodule

// File: rtl/mdio_frame.sv
`timescale 1ns/1ps
module mdio_frame #(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              start,
  input  logic              op_write,
  input  logic              nopre,
  input  logic [ADDR_W-1:0] phy_ad,
  input  logic [ADDR_W-1:0] reg_ad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mdio_i,
  output logic              active,
  output logic              launch,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int HDR_W     = 4 + 2*ADDR_W + 2 + DATA_W;
  localparam int FRAME_LEN = PRE_LEN + HDR_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_POS    = PRE_LEN + 4 + 2*ADDR_W;
  localparam int DATA_POS  = TA_POS + 2;

  logic [IDX_W-1:0] idx;
  logic [HDR_W-1:0] hdr;
  logic             is_wr, in_pre, at_last;

  assign in_pre  = (idx < IDX_W'(PRE_LEN));
  assign at_last = (idx == IDX_W'(FRAME_LEN - 1));
  assign launch  = fall_stb & start & (~active | at_last);
  assign done    = fall_stb & active & at_last;
  assign mdio_o  = active & (in_pre | hdr[HDR_W-1]);
  assign mdio_oe = active & (is_wr | (idx < IDX_W'(TA_POS)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      hdr    <= '0;
      is_wr  <= 1'b0;
      rdata  <= '0;
    end else begin
      if (launch) begin
        active <= 1'b1;
        idx    <= nopre ? IDX_W'(PRE_LEN) : '0;
        is_wr  <= op_write;
        hdr    <= {2'b01, op_write ? 2'b01 : 2'b10, phy_ad, reg_ad, 2'b10,
                   op_write ? wdata : {DATA_W{1'b0}}};
      end else if (done) begin
        active <= 1'b0;
      end else if (fall_stb && active) begin
        idx <= idx + IDX_W'(1);
        if (!in_pre) hdr <= {hdr[HDR_W-2:0], 1'b0};
      end
      if (rise_stb && active && !is_wr && idx >= IDX_W'(DATA_POS))
        rdata <= {rdata[DATA_W-2:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int MODE_W = DIV_W + 1;

  logic [MODE_W-1:0] mode_q;
  logic [2:0]        cmd_q;
  logic [ADDR_W-1:0] phy_q, rad_q;
  logic [DATA_W-1:0] txd_q, rxd_q, shreg;
  logic pending, scan_q, op_wr_q, frame_scan, link_fail, invalid;
  logic rise_stb, fall_stb, active, launch, done, busy, cmd_wr;

  assign busy   = pending | active | scan_q;
  assign cmd_wr = reg_we && (reg_addr == SEL_CMD);

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .div_field(mode_q[DIV_W-1:0]),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_frame (
    .clk(clk), .rst_n(rst_n), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .start(pending | scan_q), .op_write(op_wr_q), .nopre(mode_q[DIV_W]),
    .phy_ad(phy_q), .reg_ad(rad_q), .wdata(txd_q), .mdio_i(mdio_i),
    .active(active), .launch(launch), .done(done), .rdata(shreg),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; cmd_q <= '0; phy_q <= '0; rad_q <= '0;
      txd_q <= '0; rxd_q <= '0; pending <= 1'b0; scan_q <= 1'b0;
      op_wr_q <= 1'b0; frame_scan <= 1'b0; link_fail <= 1'b0; invalid <= 1'b0;
    end else begin
      if (reg_we && reg_addr == SEL_MODE) mode_q <= reg_wdata[MODE_W-1:0];
      if (reg_we && reg_addr == SEL_ADDR) begin
        phy_q <= reg_wdata[ADDR_W-1:0];
        rad_q <= reg_wdata[REGAD_LSB +: ADDR_W];
      end
      if (reg_we && reg_addr == SEL_TXD) txd_q <= reg_wdata;

      if (launch) begin
        pending    <= 1'b0;
        frame_scan <= scan_q;
      end
      if (done) begin
        rxd_q <= shreg;
        if (frame_scan) begin
          link_fail <= ~shreg[LINK_BIT];
          invalid   <= 1'b0;
        end
      end

      if (cmd_wr) begin
        if (reg_wdata[2:0] == 3'b000) begin
          cmd_q  <= '0;
          scan_q <= 1'b0;
        end else if (!busy) begin
          cmd_q   <= reg_wdata[2:0];
          pending <= 1'b1;
          scan_q  <= reg_wdata[CMD_SCAN];
          op_wr_q <= reg_wdata[CMD_WRITE] & ~reg_wdata[CMD_READ] & ~reg_wdata[CMD_SCAN];
          if (reg_wdata[CMD_SCAN]) invalid <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      SEL_MODE:   reg_rdata = DATA_W'(mode_q);
      SEL_CMD:    reg_rdata = DATA_W'(cmd_q);
      SEL_ADDR: begin
        reg_rdata[ADDR_W-1:0]           = phy_q;
        reg_rdata[REGAD_LSB +: ADDR_W]  = rad_q;
      end
      SEL_TXD:    reg_rdata = txd_q;
      SEL_RXD:    reg_rdata = rxd_q;
      SEL_STATUS: begin
        reg_rdata[ST_LINKFAIL] = link_fail;
        reg_rdata[ST_BUSY]     = busy;
        reg_rdata[ST_INVALID]  = invalid;
      end
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             busy,
  input logic [DIV_W-1:0] div_field
);
  logic             mdc_d, primed;
  logic [DIV_W:0]   run, exp_half;
  logic [DIV_W-1:0] div_d;

  assign exp_half = ((div_field >> 1) == '0) ? (DIV_W+1)'(1) : (DIV_W+1)'(div_field >> 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_d  <= 1'b0;
      primed <= 1'b0;
      run    <= '0;
      div_d  <= '0;
    end else begin
      mdc_d <= mdc;
      div_d <= div_field;
      run   <= (mdc != mdc_d) ? (DIV_W+1)'(1) : run + (DIV_W+1)'(1);
      if (div_field != div_d) primed <= 1'b0;
      else if (mdc != mdc_d)  primed <= 1'b1;
    end
  end

  // R1: each clock level lasts half the forced-even divider
  assert_half_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && mdc != mdc_d && div_field == div_d) |-> run == exp_half);

  // R6: data value moves only with a falling management clock
  assert_data_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $fell(mdc));

  // R6: output enable moves only with a falling management clock
  assert_oe_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> $fell(mdc));

  // R5: line driven only while a transfer is in progress
  assert_drive_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .div_field(mode_q[DIV_W-1:0])
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  localparam logic [4:0] PHY = 5'd3;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, mdio_i = 1'b1;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // ---------------- PHY model ----------------
  logic [15:0] mem [32];
  logic [31:0] fr;
  logic [15:0] rd_word;
  logic [1:0]  last_op;
  logic        phy_line, phy_drv, phy_bit;
  bit in_frame = 0, rd_hit = 0;
  int pos = 0, pre_run = 0, last_pre = -1, frames = 0;

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 16'h0F00 ^ 16'(i);
  end

  always @(posedge mdc) begin
    phy_line = mdio_oe ? mdio_o : mdio_i;
    if (!in_frame) begin
      if (!mdio_oe) pre_run = 0;
      else if (phy_line) pre_run++;
      else begin
        in_frame = 1; pos = 1; fr = 32'd0; last_pre = pre_run; pre_run = 0;
      end
    end else begin
      fr = {fr[30:0], phy_line};
      pos++;
      if (pos == 14) begin
        rd_hit  = (fr[11:10] == 2'b10) && (fr[9:5] == PHY);
        rd_word = mem[fr[4:0]];
      end
      if (pos == 32) begin
        in_frame = 0; rd_hit = 0; frames++;
        last_op = fr[29:28];
        if (fr[29:28] == 2'b01 && fr[27:23] == PHY) mem[fr[22:18]] = fr[15:0];
      end
    end
  end

  always @(negedge mdc) begin
    phy_drv = in_frame && rd_hit && pos >= 15 && pos <= 31;
    phy_bit = (pos == 15) ? 1'b0 : ((pos >= 16 && pos <= 31) ? rd_word[31-pos] : 1'b1);
    mdio_i  = phy_drv ? phy_bit : 1'b1;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [15:0] s;
    int n;
    n = 0;
    do begin rd(3'd5, s); n++; end while (s[1] && n < 40000);
    check(!s[1], req, s, 0);
  endtask

  task automatic measure(output int n);
    realtime t1;
    @(posedge mdc); @(posedge mdc); t1 = $realtime;
    @(posedge mdc); n = int'(($realtime - t1) / 5.0);
  endtask

  function automatic int exp_div(input int d);
    int e;
    e = d & ~1;
    return (e < 2) ? 2 : e;
  endfunction

  // {wr, nopre, div[7:0], phy[4:0], reg[4:0], wdata[15:0], expect[15:0]}
  localparam logic [51:0] VEC [12] = '{
    {1'b1, 1'b0, 8'd4,   5'd3, 5'd5,  16'hA5C3, 16'h0000},
    {1'b0, 1'b0, 8'd4,   5'd3, 5'd5,  16'h0000, 16'hA5C3},
    {1'b1, 1'b1, 8'd7,   5'd3, 5'd9,  16'h1234, 16'h0000},
    {1'b0, 1'b1, 8'd0,   5'd3, 5'd9,  16'h0000, 16'h1234},
    {1'b0, 1'b0, 8'd1,   5'd3, 5'd0,  16'h0000, 16'h0F00},
    {1'b0, 1'b0, 8'd6,   5'd7, 5'd2,  16'h0000, 16'hFFFF},
    {1'b1, 1'b0, 8'd6,   5'd7, 5'd9,  16'hBEEF, 16'h0000},
    {1'b0, 1'b1, 8'd10,  5'd3, 5'd9,  16'h0000, 16'h1234},
    {1'b1, 1'b0, 8'd2,   5'd3, 5'd31, 16'hFFFF, 16'h0000},
    {1'b0, 1'b1, 8'd3,   5'd3, 5'd31, 16'h0000, 16'hFFFF},
    {1'b1, 1'b1, 8'd255, 5'd3, 5'd31, 16'h0000, 16'h0000},
    {1'b0, 1'b0, 8'd2,   5'd3, 5'd31, 16'h0000, 16'h0000}
  };

  initial begin
    #750000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int per, f0;
    repeat (4) @(negedge clk);
    // R10: reset state
    rd(3'd5, v); check(v == 16'h0, "R10 status", v, 0);
    rd(3'd4, v); check(v == 16'h0, "R10 rxdata", v, 0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R10 pins", {mdc, mdio_oe}, 0);
    rst_n = 1'b1;

    foreach (VEC[k]) begin
      logic [51:0] t;
      t = VEC[k];
      wr(3'd0, {7'd0, t[50], t[49:42]});
      wr(3'd2, {3'd0, t[36:32], 3'd0, t[41:37]});
      wr(3'd3, t[31:16]);
      measure(per);
      check(per == exp_div(int'(t[49:42])), "R1 period", per, exp_div(int'(t[49:42])));
      f0 = frames;
      wr(3'd1, t[51] ? 16'd4 : 16'd2);
      rd(3'd5, v); check(v[1], "R5 busy set", v, 2);
      wait_idle("R5 busy clear");
      wr(3'd1, 16'd0);
      check(frames == f0 + 1, "R3 R4 one frame", frames - f0, 1);
      check(last_pre == (t[50] ? 0 : 32), "R2 preamble", last_pre, t[50] ? 0 : 32);
      if (t[51]) begin
        if (t[41:37] == PHY)
          check(mem[t[36:32]] == t[31:16], "R3 write data", mem[t[36:32]], t[31:16]);
      end else begin
        rd(3'd4, v); check(v == t[15:0], "R4 read data", v, t[15:0]);
      end
    end

    // R9: command while busy ignored
    wr(3'd0, 16'd4); wr(3'd2, {3'd0, 5'd12, 3'd0, PHY}); wr(3'd3, 16'h1111);
    f0 = frames;
    wr(3'd1, 16'd4);
    wr(3'd1, 16'd2);
    wait_idle("R9 idle");
    repeat (600) @(negedge clk);
    wr(3'd1, 16'd0);
    check(frames == f0 + 1, "R9 frame count", frames - f0, 1);
    check(last_op == 2'b01 && mem[12] == 16'h1111, "R9 write kept", mem[12], 16'h1111);

    // R7: scan
    mem[1] = 16'h0000;
    wr(3'd0, 16'd4); wr(3'd2, {3'd0, 5'd1, 3'd0, PHY});
    f0 = frames;
    wr(3'd1, 16'd1);
    rd(3'd5, v); check(v[2] && v[1], "R7 invalid set", v, 6);
    begin
      int n;
      n = 0;
      do begin rd(3'd5, v); n++; end while (v[2] && n < 5000);
    end
    check(v[2:0] == 3'b011, "R7 link fail", v, 3);
    rd(3'd4, v); check(v == 16'h0000, "R7 scan data", v, 0);
    mem[1] = 16'h0004;
    f0 = frames;
    while (frames < f0 + 2) @(negedge clk);
    repeat (20) @(negedge clk);
    rd(3'd5, v); check(v[2:0] == 3'b010, "R7 link ok", v, 2);
    rd(3'd4, v); check(v == 16'h0004, "R7 scan update", v, 4);

    // R8: stop scan
    wr(3'd1, 16'd0);
    wait_idle("R8 busy clear");
    f0 = frames;
    repeat (1000) @(negedge clk);
    check(frames == f0, "R8 no new frames", frames - f0, 0);
    rd(3'd5, v); check(!v[1], "R8 idle", v, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule